// File: doc/BRIEF.md
# Micromirror Frame Load Sequencer

The sequencer pushes binary frames into a micromirror array controller one row command per clock. Row data comes from an upstream source over a valid/ready pair and goes out unchanged. The first row of a frame sets the controller's row pointer back to zero. Every later row advances that pointer by one. Once the final row of the frame is out, the sequencer sends one global reset-all command. It then follows the controller's reset-active handshake, sending no-op rows, and starts no new frame until that handshake has finished.

The mirrors must get a global clocking pulse well inside a 10-second limit. For this reason, when no user frame arrives for a programmable number of cycles, the sequencer loads keep-alive frames of its own. These are all-on and all-off frames in turn, and each one ends with its own reset handshake. A user frame that is waiting at a frame boundary always goes ahead of a keep-alive frame. The reset-active wait has a timeout, and a timeout sets a sticky error flag.

Top module: `mirror_frame_sequencer`

## Requirements
- R1: The first row of each frame goes out with row mode 2'b11. Its data equals the first accepted word, or the keep-alive fill.
- R2: Every later row of a frame goes out with row mode 2'b01. A cycle with no row to send goes out as a no-op row: row mode 2'b00 and the data lines all zero.
- R3: Each frame has exactly NUM_ROWS row commands (one 2'b11 and NUM_ROWS-1 of 2'b01). The north/south flip output stays at 0.
- R4: In the cycle after the last row, block address 4'b1000 and block mode 2'b11 appear for exactly one cycle, with a no-op row. In every other cycle the block mode is 2'b00 and the block address is 4'b0000.
- R5: From the reset-all command until reset-active has risen and then fallen, in_ready stays low and only no-op rows go out, whatever in_valid does.
- R6: Each row's data is the accepted word unchanged, with no combination with earlier frames.
- R7: frame_done is high for exactly one cycle, in the cycle after the falling edge of reset-active is seen.
- R8: With no user frame pending, the first row of a keep-alive frame appears IDLE_CYCLES+2 cycles after the frame_done cycle. Keep-alive frames alternate all ones and all zeros, starting with all ones. During a keep-alive frame keepalive is high and in_ready is low.
- R9: If in_valid is high in the cycle where the idle period expires, the user frame is loaded and no keep-alive frame starts.
- R10: If reset-active does not rise, or does not fall, within RST_TIMEOUT cycles, rst_err goes high and stays high until reset. In that case frame_done does not pulse and the sequencer returns to idle with in_ready high.
- R11: After reset the outputs show a no-op row and no block command. in_ready is high, and frame_done, rst_err and keepalive are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_data | input | ROW_W | Row word from the upstream source |
| in_valid | input | 1 | in_data holds a row |
| in_ready | output | 1 | Sequencer accepts a row this cycle |
| row_data | output | ROW_W | Row data to the controller |
| row_mode | output | 2 | Row command: 00 no-op, 01 increment, 11 pointer reset |
| blk_addr | output | 4 | Block address of the block command |
| blk_mode | output | 2 | Block command, 11 with address 1000 is reset-all |
| ns_flip | output | 1 | North/south flip flag, held at 0 |
| rst_active | input | 1 | Controller's reset-active handshake |
| frame_done | output | 1 | Pulse when a frame's handshake completes |
| rst_err | output | 1 | Sticky reset handshake timeout flag |
| keepalive | output | 1 | Current frame is a keep-alive frame |

## Verification
The hardest case to reach is a tie: the idle period expires in the same cycle that a user word becomes valid, and the user frame must win. The stimulus gets there by counting cycles exactly from the frame_done pulse and raising in_valid in the one cycle where the idle count reaches its limit. Both handshake timeouts are reached with a scripted controller model: in one case it never raises reset-active, and in the other it holds reset-active high past the limit. While a handshake is in progress the bench keeps in_valid asserted with junk data, which shows that no row is taken during that time.

// File: rtl/fls_pkg.sv
// Shared encodings and state types for the micromirror frame load sequencer.
package fls_pkg;
    localparam logic [1:0] ROWMD_NOOP  = 2'b00;
    localparam logic [1:0] ROWMD_INC   = 2'b01;
    localparam logic [1:0] ROWMD_FIRST = 2'b11;
    localparam logic [1:0] BLKMD_NONE  = 2'b00;
    localparam logic [1:0] BLKMD_RST   = 2'b11;
    localparam logic [3:0] BLKAD_NONE  = 4'b0000;
    localparam logic [3:0] BLKAD_ALL   = 4'b1000;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_LOAD,
        SQ_RSTCMD,
        SQ_HSHAKE
    } seq_state_t;

    typedef enum logic [1:0] {
        HS_IDLE,
        HS_RISE,
        HS_FALL
    } hs_phase_t;
endpackage

// File: rtl/fls_row_counter.sv
// Counts the row commands issued in the current frame.
// start loads a count of one (the pointer-reset row), and step adds one row.
// is_last tells the sequencer that the next row it issues closes the frame.
// Assumes start and step are never high in the same cycle.
module fls_row_counter #(
    parameter int NUM_ROWS = 1600
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic step,
    output logic is_last
);
    localparam int CNT_W = $clog2(NUM_ROWS + 1);
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(NUM_ROWS - 1);
    localparam logic [CNT_W-1:0] FULL     = CNT_W'(NUM_ROWS);

    logic [CNT_W-1:0] cnt;

    // Row count register: load on frame start, advance per issued row.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (start) begin
            cnt <= CNT_W'(1);
        end else if (step) begin
            cnt <= cnt + CNT_W'(1);
        end
    end

    assign is_last = (cnt == LAST_IDX);

    // R3: a frame never carries more than NUM_ROWS rows.
    assert_row_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= FULL);
    assert_no_extra_row_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(step && (cnt == FULL)));
endmodule

// File: rtl/fls_idle_timer.sv
// Counts idle cycles since the last completed reset handshake.
// The count saturates at IDLE_CYCLES, and expired then asks for a keep-alive frame.
// clear wins over run. Assumes IDLE_CYCLES is well under the mirror clocking deadline.
module fls_idle_timer #(
    parameter int IDLE_CYCLES = 1_000_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic run,
    output logic expired
);
    localparam int IDLE_W = $clog2(IDLE_CYCLES + 1);
    localparam logic [IDLE_W-1:0] LIMIT = IDLE_W'(IDLE_CYCLES);

    logic [IDLE_W-1:0] cnt;

    // Saturating idle counter.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cnt <= '0;
        end else if (run && (cnt != LIMIT)) begin
            cnt <= cnt + IDLE_W'(1);
        end
    end

    assign expired = (cnt == LIMIT);

    // R8: the count stays within its limit.
    assert_idle_saturates_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LIMIT);
endmodule

// File: rtl/fls_rst_handshake.sv
// Follows the controller's reset-active handshake after a reset-all command.
// It first waits for a rising edge, then for the level to go low.
// Each phase has a budget of RST_TIMEOUT cycles. When a budget runs out,
// timeout pulses and err is set and held until reset.
// Assumes rst_active is synchronous to clk.
module fls_rst_handshake #(
    parameter int RST_TIMEOUT = 100_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic rst_active,
    output logic done,
    output logic timeout,
    output logic err
);
    import fls_pkg::*;

    localparam int TO_W = $clog2(RST_TIMEOUT + 1);
    localparam logic [TO_W-1:0] T_LAST = TO_W'(RST_TIMEOUT - 1);

    hs_phase_t       phase;
    logic [TO_W-1:0] timer;
    logic            act_q;
    logic            rise;

    assign rise = rst_active && !act_q;

    // Phase sequencing, per-phase timer and result pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase   <= HS_IDLE;
            timer   <= '0;
            act_q   <= 1'b0;
            done    <= 1'b0;
            timeout <= 1'b0;
            err     <= 1'b0;
        end else begin
            act_q   <= rst_active;
            done    <= 1'b0;
            timeout <= 1'b0;
            case (phase)
                HS_IDLE: begin
                    if (start) begin
                        phase <= HS_RISE;
                        timer <= '0;
                    end
                end
                HS_RISE: begin
                    if (rise) begin
                        phase <= HS_FALL;
                        timer <= '0;
                    end else if (timer == T_LAST) begin
                        phase   <= HS_IDLE;
                        timeout <= 1'b1;
                        err     <= 1'b1;
                    end else begin
                        timer <= timer + TO_W'(1);
                    end
                end
                HS_FALL: begin
                    if (!rst_active) begin
                        phase <= HS_IDLE;
                        done  <= 1'b1;
                    end else if (timer == T_LAST) begin
                        phase   <= HS_IDLE;
                        timeout <= 1'b1;
                        err     <= 1'b1;
                    end else begin
                        timer <= timer + TO_W'(1);
                    end
                end
                default: phase <= HS_IDLE;
            endcase
        end
    end

    // R10: the error flag never clears without reset.
    assert_err_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> err);
    // R7: completion is a single-cycle pulse.
    assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R10: a timeout never reports completion at the same time.
    assert_timeout_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && timeout));
endmodule

// File: rtl/mirror_frame_sequencer.sv
// Top level of the frame load sequencer.
// It accepts rows over valid/ready and issues pointer-reset and increment row
// commands, then one reset-all command, and follows the reset-active handshake.
// When no user frame arrives it loads all-on and all-off keep-alive frames in turn.
// Assumes the controller consumes one command per clock and rst_active is synchronous.
module mirror_frame_sequencer #(
    parameter int ROW_W       = 64,
    parameter int NUM_ROWS    = 1600,
    parameter int IDLE_CYCLES = 1_000_000_000,
    parameter int RST_TIMEOUT = 100_000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ROW_W-1:0] in_data,
    input  logic             in_valid,
    output logic             in_ready,
    output logic [ROW_W-1:0] row_data,
    output logic [1:0]       row_mode,
    output logic [3:0]       blk_addr,
    output logic [1:0]       blk_mode,
    output logic             ns_flip,
    input  logic             rst_active,
    output logic             frame_done,
    output logic             rst_err,
    output logic             keepalive
);
    import fls_pkg::*;

    localparam bit SINGLE_ROW = (NUM_ROWS == 1);

    seq_state_t       state;
    logic             ka_src;
    logic             ka_pol;
    logic [ROW_W-1:0] ka_fill;
    logic             start_user;
    logic             start_ka;
    logic             frame_start;
    logic             row_step;
    logic             is_last;
    logic             idle_exp;
    logic             hs_done;
    logic             hs_timeout;
    logic             hs_end;

    assign ka_fill     = ka_pol ? '0 : '1;
    assign in_ready    = (state == SQ_IDLE) || ((state == SQ_LOAD) && !ka_src);
    assign start_user  = (state == SQ_IDLE) && in_valid;
    assign start_ka    = (state == SQ_IDLE) && !in_valid && idle_exp;
    assign frame_start = start_user || start_ka;
    assign row_step    = (state == SQ_LOAD) && (ka_src || in_valid);
    assign hs_end      = (state == SQ_HSHAKE) && (hs_done || hs_timeout);
    assign ns_flip     = 1'b0;
    assign frame_done  = hs_done;
    assign keepalive   = ka_src && (state != SQ_IDLE);

    fls_row_counter #(.NUM_ROWS(NUM_ROWS)) u_rows (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (frame_start),
        .step    (row_step),
        .is_last (is_last)
    );

    fls_idle_timer #(.IDLE_CYCLES(IDLE_CYCLES)) u_idle (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (hs_end),
        .run     (state == SQ_IDLE),
        .expired (idle_exp)
    );

    fls_rst_handshake #(.RST_TIMEOUT(RST_TIMEOUT)) u_hs (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (state == SQ_RSTCMD),
        .rst_active (rst_active),
        .done       (hs_done),
        .timeout    (hs_timeout),
        .err        (rst_err)
    );

    // Frame state machine with keep-alive source and polarity tracking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= SQ_IDLE;
            ka_src <= 1'b0;
            ka_pol <= 1'b0;
        end else begin
            case (state)
                SQ_IDLE: begin
                    if (frame_start) begin
                        ka_src <= start_ka;
                        state  <= SINGLE_ROW ? SQ_RSTCMD : SQ_LOAD;
                    end
                end
                SQ_LOAD: begin
                    if (row_step && is_last) state <= SQ_RSTCMD;
                end
                SQ_RSTCMD: state <= SQ_HSHAKE;
                SQ_HSHAKE: begin
                    if (hs_end) begin
                        state <= SQ_IDLE;
                        if (ka_src) ka_pol <= ~ka_pol;
                    end
                end
                default: state <= SQ_IDLE;
            endcase
        end
    end

    // Registered command outputs, a no-op row unless a row or block command is due.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_mode <= ROWMD_NOOP;
            row_data <= '0;
            blk_mode <= BLKMD_NONE;
            blk_addr <= BLKAD_NONE;
        end else begin
            row_mode <= ROWMD_NOOP;
            row_data <= '0;
            blk_mode <= BLKMD_NONE;
            blk_addr <= BLKAD_NONE;
            if (start_user) begin
                row_mode <= ROWMD_FIRST;
                row_data <= in_data;
            end else if (start_ka) begin
                row_mode <= ROWMD_FIRST;
                row_data <= ka_fill;
            end else if (row_step) begin
                row_mode <= ROWMD_INC;
                row_data <= ka_src ? ka_fill : in_data;
            end else if (state == SQ_RSTCMD) begin
                blk_mode <= BLKMD_RST;
                blk_addr <= BLKAD_ALL;
            end
        end
    end

    // R1: an idle cycle with a valid word opens a frame with the pointer-reset mode.
    assert_first_row_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SQ_IDLE && in_valid) |=> (row_mode == ROWMD_FIRST));
    // R4: the reset-all command follows the last row.
    assert_rst_cmd_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SQ_RSTCMD) |=> (blk_mode == BLKMD_RST && blk_addr == BLKAD_ALL
                                  && row_mode == ROWMD_NOOP));
    // R5: only no-op rows while the handshake is open.
    assert_hshake_noop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SQ_HSHAKE) |=> (row_mode == ROWMD_NOOP && row_data == '0));
    // R9: a waiting user word beats the keep-alive request.
    assert_user_priority_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SQ_IDLE && in_valid) |=> !keepalive);
    // R7: completion is reported only while the sequencer is in the handshake.
    assert_done_in_hshake_R7: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> (state == SQ_HSHAKE));
endmodule

// File: tb/mirror_frame_sequencer_bench.sv
module mirror_frame_sequencer_bench;
    localparam int IW  = 16;
    localparam int NR  = 8;
    localparam int IDL = 40;
    localparam int TO  = 30;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [IW-1:0] in_data = '0;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [IW-1:0] row_data;
    logic [1:0]    row_mode;
    logic [3:0]    blk_addr;
    logic [1:0]    blk_mode;
    logic          ns_flip;
    logic          rst_active = 1'b0;
    logic          frame_done;
    logic          rst_err;
    logic          keepalive;

    int tests = 0;
    int fails = 0;

    logic [IW-1:0] exp_rows [NR];
    logic [IW-1:0] cap [NR];
    int cap_cnt = 0;
    int m01 = 0;
    int noop_bad = 0;
    int blk_bad = 0;
    int flip_bad = 0;

    always #10 clk = ~clk;

    mirror_frame_sequencer #(
        .ROW_W(IW), .NUM_ROWS(NR), .IDLE_CYCLES(IDL), .RST_TIMEOUT(TO)
    ) u_mirror_frame_sequencer (
        .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_valid(in_valid),
        .in_ready(in_ready), .row_data(row_data), .row_mode(row_mode),
        .blk_addr(blk_addr), .blk_mode(blk_mode), .ns_flip(ns_flip),
        .rst_active(rst_active), .frame_done(frame_done), .rst_err(rst_err),
        .keepalive(keepalive)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Row monitor: captures frames and flags malformed commands.
    always @(negedge clk) begin
        if (rst_n) begin
            if (ns_flip !== 1'b0) flip_bad++;
            if (row_mode == 2'b11) begin
                cap[0] = row_data;
                cap_cnt = 1;
                m01 = 0;
            end else if (row_mode == 2'b01) begin
                if (cap_cnt < NR) cap[cap_cnt] = row_data;
                cap_cnt++;
                m01++;
            end else if (row_mode == 2'b00) begin
                if (row_data !== '0) noop_bad++;
            end else begin
                noop_bad++;
            end
            if (blk_mode == 2'b11) begin
                if (blk_addr !== 4'b1000 || row_mode !== 2'b00) blk_bad++;
            end else if (blk_mode !== 2'b00 || blk_addr !== 4'b0000) begin
                blk_bad++;
            end
        end
    end

    function automatic logic [IW-1:0] pick_word();
        return IW'($urandom);
    endfunction

    task automatic send_frame(input bit gaps);
        bit rdy;
        for (int r = 0; r < NR; r++) begin
            exp_rows[r] = pick_word();
            if (gaps) begin
                in_valid = 1'b0;
                repeat ($urandom_range(0, 2)) @(negedge clk);
            end
            in_valid = 1'b1;
            in_data  = exp_rows[r];
            forever begin
                rdy = in_ready;
                @(negedge clk);
                if (rdy) break;
            end
        end
        in_valid = 1'b0;
        in_data  = '0;
    endtask

    task automatic wait_rst_cmd();
        int w = 0;
        while (blk_mode !== 2'b11 && w < 5000) begin
            @(negedge clk);
            w++;
        end
        chk("R4 reset-all block address", 64'(blk_addr), 64'h8);
        chk("R3 rows before reset-all", 64'(cap_cnt), 64'(NR));
    endtask

    // Controller model: waits, pulses reset-active, probes in_ready and rows meanwhile.
    task automatic do_handshake(input int dly, input int hold);
        int bad = 0;
        int w = 0;
        wait_rst_cmd();
        in_valid = 1'b1;
        in_data  = 16'hDEAD;
        repeat (dly) begin
            @(negedge clk);
            if (in_ready || row_mode !== 2'b00 || row_data !== '0) bad++;
        end
        rst_active = 1'b1;
        repeat (hold) begin
            @(negedge clk);
            if (in_ready || row_mode !== 2'b00 || row_data !== '0) bad++;
        end
        rst_active = 1'b0;
        while (!frame_done && w < 100) begin
            @(negedge clk);
            if (!frame_done && (in_ready || row_mode !== 2'b00)) bad++;
            w++;
        end
        in_valid = 1'b0;
        in_data  = '0;
        chk("R5 no row taken during handshake", 64'(bad), 64'h0);
        chk("R7 frame_done seen", 64'(frame_done), 64'h1);
        @(negedge clk);
        chk("R7 frame_done single cycle", 64'(frame_done), 64'h0);
    endtask

    task automatic verify_frame(input string tag);
        int mism = 0;
        for (int r = 0; r < NR; r++) if (cap[r] !== exp_rows[r]) mism++;
        chk({"R1 first row data ", tag}, 64'(cap[0]), 64'(exp_rows[0]));
        chk({"R2 increment row count ", tag}, 64'(m01), 64'(NR - 1));
        chk({"R3 total rows ", tag}, 64'(cap_cnt), 64'(NR));
        chk({"R6 row data unchanged ", tag}, 64'(mism), 64'h0);
    endtask

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_0017));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11: reset state.
        chk("R11 row mode after reset", 64'(row_mode), 64'h0);
        chk("R11 block mode after reset", 64'(blk_mode), 64'h0);
        chk("R11 in_ready after reset", 64'(in_ready), 64'h1);
        chk("R11 flags after reset", 64'({frame_done, rst_err, keepalive}), 64'h0);

        // Directed frame with gap-free rows.
        send_frame(1'b0);
        do_handshake(3, 4);
        verify_frame("directed");

        // Random frames with random gaps and handshake timing.
        for (int f = 0; f < 6; f++) begin
            send_frame(1'b1);
            do_handshake($urandom_range(0, 4), $urandom_range(1, 5));
            verify_frame("random");
        end

        // R8: keep-alive timing and all-on fill.
        begin
            int n = 0;
            while (row_mode !== 2'b11 && n < 1000) begin
                @(negedge clk);
                n++;
            end
            chk("R8 keep-alive start delay", 64'(n + 1), 64'(IDL + 2));
            chk("R8 keepalive flag", 64'(keepalive), 64'h1);
            chk("R8 in_ready low in keep-alive", 64'(in_ready), 64'h0);
        end
        for (int r = 0; r < NR; r++) exp_rows[r] = '1;
        do_handshake(2, 2);
        verify_frame("keep-alive on R8");

        // R8: the next keep-alive frame is all-off.
        for (int r = 0; r < NR; r++) exp_rows[r] = '0;
        do_handshake(1, 3);
        verify_frame("keep-alive off R8");

        // R9: user word arrives exactly at expiry.
        repeat (IDL) @(negedge clk);
        send_frame(1'b0);
        chk("R9 user frame not keep-alive", 64'(keepalive), 64'h0);
        do_handshake(2, 2);
        verify_frame("tie R9");

        chk("R3 flip flag stayed low", 64'(flip_bad), 64'h0);
        chk("R2 no-op rows clean", 64'(noop_bad), 64'h0);
        chk("R4 block command only after last row", 64'(blk_bad), 64'h0);
        chk("R10 no error before timeout", 64'(rst_err), 64'h0);

        // R10: reset-active never rises.
        begin
            int seen = 0;
            send_frame(1'b1);
            wait_rst_cmd();
            repeat (TO + 5) begin
                @(negedge clk);
                if (frame_done) seen++;
            end
            chk("R10 error after missing rise", 64'(rst_err), 64'h1);
            chk("R10 no frame_done on timeout", 64'(seen), 64'h0);
            chk("R10 back to idle", 64'(in_ready), 64'h1);
        end

        // R10: reset-active never falls.
        begin
            int seen = 0;
            send_frame(1'b0);
            wait_rst_cmd();
            rst_active = 1'b1;
            repeat (TO + 5) begin
                @(negedge clk);
                if (frame_done) seen++;
            end
            rst_active = 1'b0;
            chk("R10 no frame_done on stuck high", 64'(seen), 64'h0);
            chk("R10 idle after stuck high", 64'(in_ready), 64'h1);
        end

        // R10: flag stays set across a good frame.
        send_frame(1'b1);
        do_handshake(1, 1);
        verify_frame("after error");
        chk("R10 error sticky", 64'(rst_err), 64'h1);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule